// File: doc/BRIEF.md
# Watchdog Timer with Register Access Port

This block is a memory-mapped watchdog. Software programs a reload value, then enables the timer by writing a control code. From then on a live down-counter decrements once per clock. Software must service the timer before the counter reaches zero. If it does not, the block latches a sticky timeout flag and drives a single-cycle expiry pulse that the chip can route to its reset or interrupt logic.

The register port takes one access per cycle and carries a transfer-size code. Only half-word (16-bit) and word (32-bit) transfers are accepted. Any other size, or an address that selects no register, is rejected with a registered error code. The access then has no effect.

The block's character comes from its enable-dependent write rules. Writing the reload register preloads the counter while the timer is stopped, but is discarded while it runs. Writing the counter register services a running timer and does nothing to a stopped one.

Top module: `wdt_timer`

## Requirements
- R1: After reset the timer is disabled (code field reads 0xAD), the reload and counter registers read 0, the timeout flag is 0, `expire` is 0 and `bus_err` is 0.
- R2: Size codes are 0=8-bit, 1=16-bit, 2=32-bit and 3=64-bit. Only codes 1 and 2 are legal. Any other code gives `bus_err`=1 in the cycle after the access, and the access neither writes a register nor returns data (`bus_rdata` reads 0).
- R3: Word addresses 0 (control), 1 (reload) and 2 (counter) are mapped. A legal-size access to any other address gives `bus_err`=2 and has no effect. When the size is also illegal, the error code is 1.
- R4: While disabled, a write to the reload register stores the value and copies it into the counter.
- R5: While enabled, writes to the reload register are discarded.
- R6: While enabled, any write to the counter register reloads the counter from the reload register, and the written data is ignored.
- R7: While disabled, writes to the counter register have no effect.
- R8: Control bits [7:0] hold the enable code. The timer is enabled whenever this field differs from 0xAD.
- R9: While enabled with a nonzero counter and no reload, the counter drops by one per clock. On the step from 1 to 0, `expire` pulses high for exactly one cycle and the timeout flag (control bit 15) is set. The counter then holds at 0.
- R10: Writing 1 to control bit 15 clears the timeout flag and writing 0 leaves it unchanged. The code field is written normally by the same access, and an expiry in the same cycle wins over the clear.
- R11: A read returns the register value on `bus_rdata` in the cycle after the access, and a 16-bit read returns only the low 16 bits. A 16-bit write delivers `bus_wdata[15:0]` zero-extended. Unused control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_size | input | 2 | Transfer size code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_err | output | 2 | Error code for the previous access (0 none, 1 size, 2 address) |
| expire | output | 1 | One-cycle pulse when the counter runs out |

## Verification
The reload and counter registers are written in both the stopped and the running state. This separates preloading from discarding, and reloading from ignoring. Accesses combine legal and illegal sizes with mapped and unmapped addresses, which exposes the priority between the two error kinds and shows that rejected writes change nothing. A full run-down to zero checks the pulse width, the flag and the hold at zero. Control writes with and without bit 15 check the partial write-one-to-clear behaviour, and mixed 16/32-bit transfers check zero extension and truncation.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      SZ_8  = 2'd0,
      SZ_16 = 2'd1,
      SZ_32 = 2'd2,
      SZ_64 = 2'd3
   } size_e;

   typedef enum logic [1:0] {
      ERR_NONE = 2'd0,
      ERR_SIZE = 2'd1,
      ERR_ADDR = 2'd2
   } err_e;

   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_RELD = 2'd1,
      SEL_CNTR = 2'd2,
      SEL_NONE = 2'd3
   } sel_e;

   localparam int BUS_W  = 32;
   localparam int HALF_W = 16;
endpackage

// File: rtl/wdt_access_check.sv
module wdt_access_check
   import wdt_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic                wr,
   input  logic                rd,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [1:0]          size,
   input  logic [BUS_W-1:0]    wdata,
   output sel_e                sel,
   output logic                legal,
   output logic                half,
   output err_e                err_d,
   output logic [BUS_W-1:0]    wdata_eff
);
   logic size_ok;

   assign size_ok = (size == SZ_16) || (size == SZ_32);
   assign half    = (size == SZ_16);

   always_comb begin
      case (addr)
         ADDR_W'(0): sel = SEL_CTL;
         ADDR_W'(1): sel = SEL_RELD;
         ADDR_W'(2): sel = SEL_CNTR;
         default:    sel = SEL_NONE;
      endcase
   end

   assign legal = size_ok && (sel != SEL_NONE);

   always_comb begin
      err_d = ERR_NONE;
      if (wr || rd) begin
         if (!size_ok)             err_d = ERR_SIZE;
         else if (sel == SEL_NONE) err_d = ERR_ADDR;
      end
   end

   assign wdata_eff = half ? {{(BUS_W-HALF_W){1'b0}}, wdata[HALF_W-1:0]} : wdata;
endmodule

// File: rtl/wdt_ctl.sv
module wdt_ctl #(
   parameter int              CODE_W   = 8,
   parameter logic [CODE_W-1:0] DIS_CODE = 8'hAD,
   parameter int              FLAG_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl,
   input  logic [15:0]       wdata,
   input  logic              set_flag,
   output logic [CODE_W-1:0] code,
   output logic              flag,
   output logic              enabled
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code <= DIS_CODE;
      end else if (wr_ctl) begin
         code <= wdata[CODE_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                          flag <= 1'b0;
      else if (set_flag)                   flag <= 1'b1;
      else if (wr_ctl && wdata[FLAG_BIT])  flag <= 1'b0;
   end

   assign enabled = (code != DIS_CODE);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enabled,
   input  logic             wr_reld,
   input  logic             wr_cntr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] reld,
   output logic [CNT_W-1:0] cntr,
   output logic             hit_zero,
   output logic             expire
);
   logic preload, service, step;

   assign preload  = wr_reld && !enabled;
   assign service  = wr_cntr && enabled;
   assign step     = enabled && !service && (cntr != '0);
   assign hit_zero = step && (cntr == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)       reld <= '0;
      else if (preload) reld <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cntr <= '0;
      else if (preload) cntr <= wdata;
      else if (service) cntr <= reld;
      else if (step)    cntr <= cntr - CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) expire <= 1'b0;
      else        expire <= hit_zero;
   end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
   import wdt_pkg::*;
#(
   parameter int          ADDR_W   = 2,
   parameter int          CNT_W    = 32,
   parameter int          CODE_W   = 8,
   parameter logic [CODE_W-1:0] DIS_CODE = 8'hAD,
   parameter int          FLAG_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [1:0]        bus_err,
   output logic              expire
);
   if (ADDR_W < 2)                    begin : g_bad_addr $error("ADDR_W too small"); end
   if (CNT_W < 2 || CNT_W > BUS_W)    begin : g_bad_cnt  $error("CNT_W out of range"); end
   if (FLAG_BIT < CODE_W || FLAG_BIT >= HALF_W) begin : g_bad_flag $error("FLAG_BIT misplaced"); end

   sel_e              sel;
   logic              legal, half;
   err_e              err_d;
   logic [BUS_W-1:0]  wdata_eff;
   logic [CODE_W-1:0] code;
   logic              ctl_flag, en, hit_zero;
   logic [CNT_W-1:0]  reld_q, cntr_q;
   logic [BUS_W-1:0]  ctl_word, reld_word, cntr_word, rd_mux;
   logic              wr_ok;

   wdt_access_check #(.ADDR_W(ADDR_W)) u_acc (
      .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .size(bus_size),
      .wdata(bus_wdata), .sel(sel), .legal(legal), .half(half),
      .err_d(err_d), .wdata_eff(wdata_eff)
   );

   assign wr_ok = bus_wr && legal;

   wdt_ctl #(.CODE_W(CODE_W), .DIS_CODE(DIS_CODE), .FLAG_BIT(FLAG_BIT)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ok && sel == SEL_CTL),
      .wdata(wdata_eff[HALF_W-1:0]), .set_flag(hit_zero),
      .code(code), .flag(ctl_flag), .enabled(en)
   );

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .enabled(en),
      .wr_reld(wr_ok && sel == SEL_RELD), .wr_cntr(wr_ok && sel == SEL_CNTR),
      .wdata(wdata_eff[CNT_W-1:0]), .reld(reld_q), .cntr(cntr_q),
      .hit_zero(hit_zero), .expire(expire)
   );

   always_comb begin
      ctl_word = '0;
      ctl_word[CODE_W-1:0] = code;
      ctl_word[FLAG_BIT]   = ctl_flag;
   end

   if (CNT_W < BUS_W) begin : g_pad
      assign reld_word = {{(BUS_W-CNT_W){1'b0}}, reld_q};
      assign cntr_word = {{(BUS_W-CNT_W){1'b0}}, cntr_q};
   end else begin : g_full
      assign reld_word = reld_q;
      assign cntr_word = cntr_q;
   end

   always_comb begin
      case (sel)
         SEL_CTL:  rd_mux = ctl_word;
         SEL_RELD: rd_mux = reld_word;
         SEL_CNTR: rd_mux = cntr_word;
         default:  rd_mux = '0;
      endcase
      if (half) rd_mux[BUS_W-1:HALF_W] = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= ERR_NONE;
      end else begin
         bus_rdata <= (bus_rd && legal) ? rd_mux : '0;
         bus_err   <= err_d;
      end
   end
endmodule

module wdt_timer_chk #(
   parameter int ADDR_W = 2,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_size,
   input logic [1:0]        bus_err,
   input logic              expire,
   input logic              flag,
   input logic              enabled,
   input logic [CNT_W-1:0]  reld,
   input logic [CNT_W-1:0]  cntr
);
   logic sz_ok, wr_reld, wr_cntr;
   assign sz_ok   = (bus_size == 2'd1) || (bus_size == 2'd2);
   assign wr_reld = bus_wr && sz_ok && (bus_addr == ADDR_W'(1));
   assign wr_cntr = bus_wr && sz_ok && (bus_addr == ADDR_W'(2));

   assert_bad_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr || bus_rd) && !sz_ok |=> bus_err == 2'd1);
   assert_reld_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      enabled && !wr_reld |=> $stable(reld));
   assert_reld_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      enabled && wr_reld |=> $stable(reld));
   assert_cntr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled && !wr_reld |=> $stable(cntr));
   assert_cntr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      enabled && cntr != '0 && !wr_cntr |=> cntr == $past(cntr) - CNT_W'(1));
   assert_expire_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);
   assert_expire_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> flag);
endmodule

bind wdt_timer wdt_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_size(bus_size), .bus_err(bus_err),
   .expire(expire), .flag(ctl_flag), .enabled(en), .reld(reld_q), .cntr(cntr_q)
);

// File: tb/test_wdt_timer.sv
module test_wdt_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]  bus_addr = '0, bus_size = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  bus_err;
   logic        expire;

   int checks = 0, errors = 0, cycles = 0;
   string cur_req = "R1";

   // reference model state
   logic [7:0]  m_code;
   logic        m_flag, m_exp;
   logic [31:0] m_reld, m_cntr, m_rdata, m_wd, m_v;
   logic [1:0]  m_err;
   bit          m_ok, m_dec, m_en, m_reload, m_pre;

   always #5 clk = ~clk;

   wdt_timer i_wdt_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .expire(expire)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_code = 8'hAD; m_flag = 0; m_exp = 0; m_reld = 0; m_cntr = 0;
         m_rdata = 0; m_err = 0;
      end else begin
         m_ok  = (bus_size == 2'd1) || (bus_size == 2'd2);
         m_dec = (bus_addr <= 2'd2);
         m_en  = (m_code != 8'hAD);
         m_wd  = (bus_size == 2'd1) ? {16'h0, bus_wdata[15:0]} : bus_wdata;
         m_err = !(bus_wr || bus_rd) ? 2'd0 : !m_ok ? 2'd1 : !m_dec ? 2'd2 : 2'd0;
         m_v = 0;
         if (bus_rd && m_ok && m_dec) begin
            if (bus_addr == 0)      m_v = {16'h0, m_flag, 7'h0, m_code};
            else if (bus_addr == 1) m_v = m_reld;
            else                    m_v = m_cntr;
            if (bus_size == 2'd1) m_v = m_v & 32'hFFFF;
         end
         m_rdata  = m_v;
         m_reload = bus_wr && m_ok && bus_addr == 2 && m_en;
         m_pre    = bus_wr && m_ok && bus_addr == 1 && !m_en;
         m_exp    = 0;
         if (m_reload)   m_cntr = m_reld;
         else if (m_pre) begin m_reld = m_wd; m_cntr = m_wd; end
         else if (m_en && m_cntr != 0) begin
            if (m_cntr == 1) begin m_exp = 1; end
            m_cntr = m_cntr - 1;
         end
         if (bus_wr && m_ok && bus_addr == 0) begin
            m_code = m_wd[7:0];
            if (m_wd[15]) m_flag = 0;
         end
         if (m_exp) m_flag = 1;
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         checks++;
         if (bus_rdata !== m_rdata || bus_err !== m_err || expire !== m_exp) begin
            errors++;
            $display("FAIL %s: rdata=%h err=%0d exp=%0b expected rdata=%h err=%0d exp=%0b",
                     cur_req, bus_rdata, bus_err, expire, m_rdata, m_err, m_exp);
         end
      end
      if (cycles > 5000) begin
         errors++;
         $display("FAIL watchdog: cycles=%0d expected <= 5000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic acc(input bit w, input bit r, input logic [1:0] a,
                      input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_size = sz; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; bus_wdata = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      cur_req = "R1";
      acc(0, 1, 0, 2, 0); acc(0, 1, 1, 2, 0); acc(0, 1, 2, 2, 0);
      cur_req = "R4";
      acc(1, 0, 1, 1, 32'hFFFF_0028); acc(0, 1, 2, 2, 0); acc(0, 1, 1, 2, 0);
      cur_req = "R2";
      acc(1, 0, 1, 0, 32'h9); acc(1, 0, 1, 3, 32'h9); acc(0, 1, 1, 0, 0);
      acc(0, 1, 1, 2, 0);
      cur_req = "R3";
      acc(1, 0, 3, 3, 32'h1); acc(1, 0, 3, 2, 32'h1); acc(0, 1, 3, 1, 0);
      cur_req = "R7";
      acc(1, 0, 2, 2, 32'd77); acc(0, 1, 2, 2, 0);
      cur_req = "R8";
      acc(1, 0, 0, 1, 32'h0001); acc(0, 1, 2, 2, 0); acc(0, 1, 2, 2, 0);
      cur_req = "R5";
      acc(1, 0, 1, 2, 32'd100); acc(0, 1, 1, 2, 0);
      cur_req = "R9";
      repeat (50) @(negedge clk);
      acc(0, 1, 0, 2, 0); acc(0, 1, 2, 2, 0);
      cur_req = "R6";
      acc(1, 0, 2, 2, 32'd123); acc(0, 1, 2, 2, 0);
      cur_req = "R10";
      acc(1, 0, 0, 2, 32'h0000_0001); acc(0, 1, 0, 2, 0);
      acc(1, 0, 0, 2, 32'h0000_8001); acc(0, 1, 0, 2, 0);
      cur_req = "R9";
      repeat (50) @(negedge clk);
      cur_req = "R10";
      acc(1, 0, 0, 1, 32'h0000_80AD); acc(0, 1, 0, 1, 0);
      cur_req = "R11";
      acc(1, 0, 1, 2, 32'h1234_5678); acc(0, 1, 1, 1, 0); acc(0, 1, 1, 2, 0);
      acc(1, 0, 1, 1, 32'hFFFF_ABCD); acc(0, 1, 1, 2, 0); acc(0, 1, 2, 2, 0);
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule